// File: doc/BRIEF.md
# GPIO Port Controller with Interrupt Logic

This block is a register-mapped general purpose I/O port of up to 32 lines. Software drives output levels and per-line direction, reads back the external pin values, and configures each line as an interrupt source. Every control register has two write addresses: writing ones at the first address sets the selected bits, and writing ones at the second clears them, so no read-modify-write is ever needed.

Incoming pins pass through a two-flop synchronizer and then a per-line filter register. With a line's debounce bit set, the filter only takes a new level once it has differed from the held value for `DEB_CYCLES` consecutive clocks. Interrupt detection works on the filtered value. Each line can trigger on a rising edge, falling edge, high level, low level, or on both edges. Edge events are latched until acknowledged. Level conditions track the filtered input. Enabled, unmasked pending lines appear in the status register and are ORed onto a single interrupt output, which has its own gate bit.

The bus is a plain 32-bit register port with byte address, write strobe, write data, read strobe and registered read data. Read data appears on the clock edge after the read strobe is sampled.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Each control register (output data 0x000/0x004, direction 0x010/0x014, interrupt enable 0x020/0x024, interrupt mask 0x030/0x034, edge select 0x040/0x044, polarity 0x050/0x054, debounce 0x060/0x064, both-edge 0x0B0/0x0B4) sets the bits written as 1 at its first address and clears the bits written as 1 at its second. Bits written as 0 keep their value. Reading either address, and 0x018 for direction or 0x0B8 for both-edge, returns the current value.
- R2: After reset every register, the latched interrupts, `pin_oe`, `pin_out`, `irq_out` and all readable values are 0.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals output data ANDed with direction, so a line never drives a 1 while it is an input.
- R4: With debounce off, reading 0x080 returns the pin levels, which have passed a two-flop synchronizer and one filter register.
- R5: With a line's debounce bit set, a pin change shorter than `DEB_CYCLES` clocks leaves the value read at 0x080 unchanged. A change held longer is accepted.
- R6: The trigger type is set by the edge and polarity bits. Edge=1 with polarity=1 selects rising edges, edge=1 with polarity=0 selects falling edges, edge=0 with polarity=1 selects a high level, and edge=0 with polarity=0 selects a low level.
- R7: A line whose both-edge bit is set triggers on both rising and falling edges, whatever its edge and polarity bits hold, and never acts as a level source.
- R8: A latched edge interrupt stays pending until a 1 is written to that line's bit at address 0x078. Writing a 0 to that bit has no effect.
- R9: An edge arriving in the same cycle as its acknowledge remains pending.
- R10: A level interrupt is not latched. It follows the filtered input and is unaffected by acknowledge writes.
- R11: The status register at 0x070 shows a line only while its enable bit is 1 and its mask bit is 0.
- R12: Bit 0 of the register at 0x0A0 gates the output. `irq_out` is registered and equals that bit ANDed with the OR of all status bits, one clock later.
- R13: An edge that occurs while a line's enable bit is 0 is not recorded. Clearing enable also drops any latched edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NUM_LINES | External pin levels (asynchronous) |
| pin_out | output | NUM_LINES | Output data, gated by direction |
| pin_oe | output | NUM_LINES | Per-line output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `rst` is held for at least one clock at start-up, and that the bus never asserts read and write in the same cycle. They also assume acknowledge writes carry a line's bit only when software intends to clear that line. The stimulus keeps to these rules: every bus access is a single-cycle strobe issued from one task, and pins change only on the falling clock edge. The race between an edge and its acknowledge is set up by counting the synchronizer and filter stages exactly, so that the acknowledge write lands in the cycle where the edge is detected.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int DATA_W = 32;

  // Per-line control fields, each with set and clear write addresses
  typedef enum logic [2:0] {
    F_DOUT = 3'd0,
    F_DIR  = 3'd1,
    F_EN   = 3'd2,
    F_MASK = 3'd3,
    F_EDGE = 3'd4,
    F_POL  = 3'd5,
    F_DEB  = 3'd6,
    F_DUAL = 3'd7
  } field_e;

  localparam int NUM_FIELDS = 8;

  localparam logic [7:0] A_DIR_ST  = 8'h18;
  localparam logic [7:0] A_STATUS  = 8'h70;
  localparam logic [7:0] A_EOI     = 8'h78;
  localparam logic [7:0] A_PINS    = 8'h80;
  localparam logic [7:0] A_COMB    = 8'hA0;
  localparam logic [7:0] A_DUAL_ST = 8'hB8;

  function automatic logic [7:0] set_addr(input int f);
    case (f)
      0:       return 8'h00;
      1:       return 8'h10;
      2:       return 8'h20;
      3:       return 8'h30;
      4:       return 8'h40;
      5:       return 8'h50;
      6:       return 8'h60;
      default: return 8'hB0;
    endcase
  endfunction

  function automatic logic [7:0] clr_addr(input int f);
    return set_addr(f) + 8'h04;
  endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (set_stb) q <= q | wbits;
    else if (clr_stb) q <= q & ~wbits;
  end
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int N          = 32,
  parameter int DEB_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] deb_en,
  output logic [N-1:0] filt
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic          meta_q, sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q  <= 1'b0;
        sync_q  <= 1'b0;
        filt[i] <= 1'b0;
        cnt_q   <= '0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
        if (!deb_en[i]) begin
          filt[i] <= sync_q;
          cnt_q   <= '0;
        end else if (sync_q == filt[i]) begin
          cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
          filt[i] <= sync_q;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] filt,
  input  logic [N-1:0] en,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] dual,
  input  logic [N-1:0] eoi,
  output logic [N-1:0] edge_hit,
  output logic [N-1:0] latch,
  output logic [N-1:0] status
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise, fall, level_on;

  always_comb begin
    rise     = filt & ~prev_q;
    fall     = ~filt & prev_q;
    // both-edge bit wins over the edge/polarity pair
    edge_hit = en & ((dual & (rise | fall)) |
                     (~dual & edge_sel & ((pol & rise) | (~pol & fall))));
    level_on = en & ~dual & ~edge_sel & ((pol & filt) | (~pol & ~filt));
    status   = (latch | level_on) & ~mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      latch  <= '0;
    end else begin
      prev_q <= filt;
      // a fresh edge survives a simultaneous acknowledge
      latch  <= ((latch & ~eoi) | edge_hit) & en;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int DEB_CYCLES = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq_out
);
  localparam int N = NUM_LINES;

  logic [N-1:0] fld [NUM_FIELDS];
  logic [N-1:0] wbits;
  logic [N-1:0] r_dout, r_dir, r_en, r_mask, r_edge, r_pol, r_deb, r_dual;
  logic [N-1:0] filt, eoi_mask, edge_hit, edge_latch, irq_status;
  logic         comb_en;
  logic [DATA_W-1:0] rd_mux;

  assign wbits = bus_wdata[N-1:0];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    gpio_setclr_reg #(.W(N)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .set_stb (bus_wr && (bus_addr == ADDR_W'(set_addr(f)))),
      .clr_stb (bus_wr && (bus_addr == ADDR_W'(clr_addr(f)))),
      .wbits   (wbits),
      .q       (fld[f])
    );
  end

  assign r_dout = fld[F_DOUT];
  assign r_dir  = fld[F_DIR];
  assign r_en   = fld[F_EN];
  assign r_mask = fld[F_MASK];
  assign r_edge = fld[F_EDGE];
  assign r_pol  = fld[F_POL];
  assign r_deb  = fld[F_DEB];
  assign r_dual = fld[F_DUAL];

  assign eoi_mask = (bus_wr && bus_addr == ADDR_W'(A_EOI)) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) comb_en <= 1'b0;
    else if (bus_wr && bus_addr == ADDR_W'(A_COMB)) comb_en <= bus_wdata[0];
  end

  gpio_in_filter #(.N(N), .DEB_CYCLES(DEB_CYCLES)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .deb_en (r_deb),
    .filt   (filt)
  );

  gpio_irq_detect #(.N(N)) u_det (
    .clk      (clk),
    .rst      (rst),
    .filt     (filt),
    .en       (r_en),
    .mask     (r_mask),
    .edge_sel (r_edge),
    .pol      (r_pol),
    .dual     (r_dual),
    .eoi      (eoi_mask),
    .edge_hit (edge_hit),
    .latch    (edge_latch),
    .status   (irq_status)
  );

  always_comb begin
    rd_mux = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (bus_addr == ADDR_W'(set_addr(f)) || bus_addr == ADDR_W'(clr_addr(f)))
        rd_mux[N-1:0] = fld[f];
    end
    if (bus_addr == ADDR_W'(A_DIR_ST))  rd_mux[N-1:0] = r_dir;
    if (bus_addr == ADDR_W'(A_DUAL_ST)) rd_mux[N-1:0] = r_dual;
    if (bus_addr == ADDR_W'(A_STATUS))  rd_mux[N-1:0] = irq_status;
    if (bus_addr == ADDR_W'(A_PINS))    rd_mux[N-1:0] = filt;
    if (bus_addr == ADDR_W'(A_COMB))    rd_mux[0]     = comb_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pin_out   <= '0;
      pin_oe    <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      pin_oe  <= r_dir;
      pin_out <= r_dout & r_dir;
      irq_out <= comb_en & (|irq_status);
    end
  end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] en,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] pin_out,
  input logic         irq_out,
  input logic [N-1:0] status,
  input logic         comb_en,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] eoi,
  input logic [N-1:0] latch
);
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (!irq_out && pin_oe == '0 && pin_out == '0 && latch == '0));

  assert_no_drive_input_R3: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((latch & ~eoi & en) != '0) |=>
      ((latch & $past(latch & ~eoi & en)) == $past(latch & ~eoi & en)));

  assert_edge_beats_ack_R9: assert property (@(posedge clk) disable iff (rst)
    ((edge_hit & eoi) != '0) |=>
      ((latch & $past(edge_hit & eoi)) == $past(edge_hit & eoi)));

  assert_irq_raise_R12: assert property (@(posedge clk) disable iff (rst)
    (comb_en && (status != '0)) |=> irq_out);

  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!comb_en || status == '0) |=> !irq_out);
endmodule

bind gpio_irq_ctrl gpio_irq_checker #(.N(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (r_en),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out),
  .irq_out  (irq_out),
  .status   (irq_status),
  .comb_en  (comb_en),
  .edge_hit (edge_hit),
  .eoi      (eoi_mask),
  .latch    (edge_latch)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 32;
  localparam int DEB  = 8;
  localparam int AW   = 8;
  localparam int L    = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NUM_LINES(NL), .DEB_CYCLES(DEB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  function automatic logic [7:0] fset(input int f);
    logic [7:0] b [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'hB0};
    return b[f];
  endfunction

  function automatic logic [7:0] fclr(input int f);
    return fset(f) + 8'h04;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic status_bit(input string req, input logic exp);
    logic [31:0] s;
    rd(8'h70, s);
    check(req, {31'd0, s[L]}, {31'd0, exp});
  endtask

  task automatic set_pin(input logic val);
    pin_in[L] = val;
    wait_cyc(6);
  endtask

  // edge, polarity, both-edge bits for line L; enable on, mask off
  task automatic cfg(input logic e, input logic p, input logic d);
    wr(e ? fset(4) : fclr(4), 32'd1 << L);
    wr(p ? fset(5) : fclr(5), 32'd1 << L);
    wr(d ? fset(7) : fclr(7), 32'd1 << L);
    wr(fset(2), 32'd1 << L);
    wr(fclr(3), 32'd1 << L);
    wr(8'h78, 32'd1 << L);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    check("R2 irq_out", {31'd0, irq_out}, 32'd0);
    check("R2 pin_oe", pin_oe, 32'd0);
    check("R2 pin_out", pin_out, 32'd0);
    for (int f = 0; f < 8; f++) begin
      rd(fset(f), v);
      check("R2 reg", v, 32'd0);
      model[f] = '0;
    end
    rd(8'h70, v); check("R2 status", v, 32'd0);
    rd(8'hA0, v); check("R2 comb", v, 32'd0);

    // R1 / R3: random set/clear traffic against a bench model
    for (int i = 0; i < 80; i++) begin
      int f;
      logic [31:0] d;
      logic s;
      f = int'($urandom % 8);
      d = $urandom;
      s = 1'($urandom % 2);
      if (i % 10 == 0) d = 32'h0;
      wr(s ? fset(f) : fclr(f), d);
      model[f] = s ? (model[f] | d) : (model[f] & ~d);
      rd(fset(f), v); check("R1 set addr", v, model[f]);
      rd(fclr(f), v); check("R1 clr addr", v, model[f]);
      check("R3 pin_oe", pin_oe, model[1]);
      check("R3 pin_out", pin_out, model[0] & model[1]);
    end
    rd(8'h18, v); check("R1 dir status", v, model[1]);
    rd(8'hB8, v); check("R1 dual status", v, model[7]);
    for (int f = 0; f < 8; f++) wr(fclr(f), 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    check("R3 pin_oe cleared", pin_oe, 32'd0);

    // R4: synchronized pin readback
    for (int i = 0; i < 5; i++) begin
      logic [31:0] p;
      p = $urandom;
      pin_in = p;
      wait_cyc(4);
      rd(8'h80, v); check("R4 pins", v, p);
    end
    pin_in = '0;
    wait_cyc(4);

    // R5: debounce on line 0
    wr(fset(6), 32'd1);
    pin_in[0] = 1'b1; wait_cyc(3); pin_in[0] = 1'b0;
    wait_cyc(DEB + 4);
    rd(8'h80, v); check("R5 short pulse", {31'd0, v[0]}, 32'd0);
    pin_in[0] = 1'b1; wait_cyc(DEB + 6);
    rd(8'h80, v); check("R5 long level", {31'd0, v[0]}, 32'd1);
    pin_in[0] = 1'b0; wait_cyc(DEB + 6);
    wr(fclr(6), 32'd1);

    // R6 / R8: rising edge
    set_pin(1'b0);
    cfg(1'b1, 1'b1, 1'b0);
    status_bit("R6 rising idle", 1'b0);
    set_pin(1'b1);
    status_bit("R6 rising hit", 1'b1);
    wait_cyc(5);
    status_bit("R8 latched", 1'b1);
    wr(8'h78, 32'd0);
    status_bit("R8 zero ack ignored", 1'b1);
    wr(8'h78, 32'd1 << L);
    status_bit("R8 ack clears", 1'b0);
    set_pin(1'b0);
    status_bit("R6 rising ignores fall", 1'b0);

    // R6: falling edge
    cfg(1'b1, 1'b0, 1'b0);
    set_pin(1'b1);
    status_bit("R6 falling ignores rise", 1'b0);
    set_pin(1'b0);
    status_bit("R6 falling hit", 1'b1);

    // R6 / R10: high level
    cfg(1'b0, 1'b1, 1'b0);
    status_bit("R6 high idle", 1'b0);
    set_pin(1'b1);
    status_bit("R6 high hit", 1'b1);
    wr(8'h78, 32'd1 << L);
    status_bit("R10 ack no effect", 1'b1);
    set_pin(1'b0);
    status_bit("R10 follows input", 1'b0);

    // R6: low level
    cfg(1'b0, 1'b0, 1'b0);
    status_bit("R6 low hit", 1'b1);
    set_pin(1'b1);
    status_bit("R6 low idle", 1'b0);

    // R7: both edges override edge/polarity
    cfg(1'b0, 1'b1, 1'b1);
    status_bit("R7 no level action", 1'b0);
    cfg(1'b1, 1'b1, 1'b1);
    set_pin(1'b0);
    status_bit("R7 falling taken", 1'b1);
    wr(8'h78, 32'd1 << L);
    set_pin(1'b1);
    status_bit("R7 rising taken", 1'b1);
    wr(8'h78, 32'd1 << L);
    status_bit("R7 ack", 1'b0);

    // R9: edge and acknowledge in the same cycle
    set_pin(1'b0);
    status_bit("R9 older edge", 1'b1);
    pin_in[L] = 1'b1;
    wait_cyc(2);
    wr(8'h78, 32'd1 << L);
    status_bit("R9 new edge kept", 1'b1);
    wr(8'h78, 32'd1 << L);
    status_bit("R9 later ack", 1'b0);

    // R11 / R12: mask and combined output
    set_pin(1'b0);
    wr(fset(3), 32'd1 << L);
    status_bit("R11 masked", 1'b0);
    wr(fclr(3), 32'd1 << L);
    status_bit("R11 unmasked", 1'b1);
    check("R12 gate off", {31'd0, irq_out}, 32'd0);
    wr(8'hA0, 32'd1);
    wait_cyc(2);
    check("R12 gate on", {31'd0, irq_out}, 32'd1);
    rd(8'hA0, v); check("R12 gate readback", v, 32'd1);
    wr(fset(3), 32'd1 << L);
    wait_cyc(2);
    check("R12 masked line", {31'd0, irq_out}, 32'd0);
    wr(fclr(3), 32'd1 << L);

    // R13 / R11: disabled lines
    wr(fclr(2), 32'd1 << L);
    status_bit("R11 disabled", 1'b0);
    set_pin(1'b1);
    wr(fset(2), 32'd1 << L);
    status_bit("R13 edge while disabled", 1'b0);
    check("R13 irq idle", {31'd0, irq_out}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule